// File: doc/BRIEF.md
# Pin Interrupt Detector with Sticky Status and Write-One-to-Clear

This block watches a bank of general-purpose input pins and turns selected pin activity into interrupt status. Each pin is given one of four trigger settings: off, rising edge, high level or low level. A detected event sets that pin's sticky status bit. The status bits are split into a lower bank of 32 and an upper bank of 8, and each bank has its own readable status register and its own clear register.

Software reads a status register and then writes a mask to the matching clear register. Only the positions written as 1 are cleared. An event that is detected in the same cycle as a clear always wins, whether the clear is aimed at that bit or at other bits, so no channel can stall because its edge was swallowed by a clear. The enabled status bits are ORed into one registered interrupt request line.

Raw pin levels pass through a fixed two-flop synchronizer. Edge detection compares the synchronized level with a copy that is one cycle older.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset every status bit reads 0, `irq` is 0, and every pin behaves as if its trigger setting were off.
- R2: With trigger setting 1 (rising edge), a 0-to-1 change on a pin sets its status bit on the third rising clock edge after the change. The bit then stays 1 after the pin falls, until it is cleared.
- R3: A write of mask M to address 2 clears the lower status bits where M is 1 on that clock edge. Bits where M is 0 keep their value.
- R4: If a pin event is detected in the same cycle as a clear aimed only at other bits, the event's bit is 1 after that edge.
- R5: If a pin event is detected in the same cycle as a clear aimed at that same bit, the bit is 1 after that edge.
- R6: With trigger setting 2 (high level), the bit is set while the synchronized pin is 1. A clear written while the pin stays high leaves the bit reading 1.
- R7: With trigger setting 3 (low level), the bit is set while the synchronized pin is 0. Once the pin is high, a clear takes effect.
- R8: With trigger setting 0 (off), pin activity never sets the status bit.
- R9: When a pin's trigger setting changes to rising edge in the cycle in which a 0-to-1 change is seen, no event is produced.
- R10: `irq` is 1 exactly one clock edge after some status bit is 1 while its `pin_en` bit is 1.
- R11: Reading has no side effects. Address 0 returns the lower status and address 1 returns the upper status in bits [7:0], with zeros above. Addresses 2 and 3 read as 0.
- R12: A write of mask M to address 3 clears the upper status bits where M[7:0] is 1. Clears of the lower bank never touch the upper bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 40 | Raw pin levels. Pins 0-31 are the lower bank and pins 32-39 the upper bank |
| pin_type | input | 80 | Trigger setting for pin i at bits [2i+1:2i]: 0 off, 1 rising, 2 high, 3 low |
| pin_en | input | 40 | Per-pin enable into the interrupt request |
| bus_addr | input | 2 | Register address: 0 lower status, 1 upper status, 2 lower clear, 3 upper clear |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data, used as a clear mask |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
A pin change reaches the status bit on the third clock edge: two synchronizer stages, then the status register. The request line follows status one edge later, and a clear takes effect on the edge that samples the write. Reads are combinational, so they can be observed in the same cycle. The bench drives its inputs 1 ns after a rising edge and advances a reference model at each rising edge using the inputs that were held across it. It then samples reads and `irq` before the next edge, so every comparison falls in the cycle in which the result is due. The directed cases count edges explicitly, for example checking that a rising edge's bit is still 0 after two edges and 1 after three.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;

  localparam logic [1:0] ADR_STAT_LO = 2'd0;
  localparam logic [1:0] ADR_STAT_HI = 2'd1;
  localparam logic [1:0] ADR_CLR_LO  = 2'd2;
  localparam logic [1:0] ADR_CLR_HI  = 2'd3;

  // Event for one pin. A rising edge only counts when the mode is unchanged since the last cycle.
  function automatic logic pin_event(trig_e mode, trig_e mode_q, logic cur, logic dly);
    logic ev;
    case (mode)
      TRIG_RISE: ev = (mode == mode_q) && cur && !dly;
      TRIG_HIGH: ev = cur;
      TRIG_LOW:  ev = !cur;
      default:   ev = 1'b0;
    endcase
    return ev;
  endfunction

  // Next value of a sticky bit: a set always wins over a clear.
  function automatic logic sticky_next(logic s, logic clr, logic set);
    return (s & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] cur,
  output logic [N-1:0] dly
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      dly    <= '0;
    end else begin
      stage1 <= d;
      cur    <= stage1;
      dly    <= cur;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*N-1:0] mode,
  input  logic [N-1:0]   cur,
  input  logic [N-1:0]   dly,
  output logic [N-1:0]   evt
);
  logic [2*N-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign evt[i] = pin_event(trig_e'(mode[2*i +: 2]), trig_e'(mode_q[2*i +: 2]),
                              cur[i], dly[i]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= sticky_next(stat[i], clr[i], evt[i]);
    end
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int LO_PINS = 32,
  parameter int HI_PINS = 8,
  parameter int DW      = 32,
  localparam int NPIN   = LO_PINS + HI_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [2*NPIN-1:0] pin_type,
  input  logic [NPIN-1:0]   pin_en,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  logic [NPIN-1:0]    pin_cur;
  logic [NPIN-1:0]    pin_dly;
  logic [NPIN-1:0]    set_evt;
  logic [NPIN-1:0]    clr_mask;
  logic [NPIN-1:0]    status;
  logic [LO_PINS-1:0] stat_lo;
  logic [HI_PINS-1:0] stat_hi;
  logic               irq_q;

  gpio_irq_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .cur(pin_cur), .dly(pin_dly)
  );

  gpio_irq_detect #(.N(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .mode(pin_type), .cur(pin_cur), .dly(pin_dly), .evt(set_evt)
  );

  assign clr_mask[LO_PINS-1:0] = (bus_we && bus_addr == ADR_CLR_LO) ?
                                 bus_wdata[LO_PINS-1:0] : '0;
  assign clr_mask[NPIN-1:LO_PINS] = (bus_we && bus_addr == ADR_CLR_HI) ?
                                    bus_wdata[HI_PINS-1:0] : '0;

  gpio_irq_bank #(.W(LO_PINS)) u_bank_lo (
    .clk(clk), .rst_n(rst_n),
    .evt(set_evt[LO_PINS-1:0]), .clr(clr_mask[LO_PINS-1:0]), .stat(stat_lo)
  );

  gpio_irq_bank #(.W(HI_PINS)) u_bank_hi (
    .clk(clk), .rst_n(rst_n),
    .evt(set_evt[NPIN-1:LO_PINS]), .clr(clr_mask[NPIN-1:LO_PINS]), .stat(stat_hi)
  );

  assign status = {stat_hi, stat_lo};

  always_comb begin
    case (bus_addr)
      ADR_STAT_LO: bus_rdata = {{(DW-LO_PINS){1'b0}}, stat_lo};
      ADR_STAT_HI: bus_rdata = {{(DW-HI_PINS){1'b0}}, stat_hi};
      default:     bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & pin_en);
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int N = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt,
  input logic [N-1:0] clr,
  input logic [N-1:0] stat,
  input logic [N-1:0] en,
  input logic         irq
);
  // R4 and R5: a detected event is present after the edge whatever clear was applied
  p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R3: only masked bits may fall
  p_clear_only_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~$past(clr) & ~stat) == '0));

  // R8: no bit rises without a detected event
  p_no_unsourced_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

  // R10: request follows enabled status one edge later
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(stat) & $past(en)))));
endmodule

bind gpio_irq_top gpio_irq_chk #(.N(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(set_evt), .clr(clr_mask),
  .stat(status), .en(pin_en), .irq(irq)
);

// File: tb/test_gpio_irq_top.sv
`timescale 1ns/100ps
module test_gpio_irq_top;
  localparam int LO = 32, HI = 8, N = 40, DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  pin_in;
  logic [2*N-1:0] pin_type;
  logic [N-1:0]  pin_en;
  logic [1:0]    bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  gpio_irq_top i_gpio_irq_top (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_type(pin_type), .pin_en(pin_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference state
  logic [N-1:0]   m_s1, m_cur, m_dly, m_stat;
  logic           m_irq;
  logic [2*N-1:0] m_typq;

  function automatic logic ref_evt(logic [1:0] t, logic [1:0] tq, logic c, logic d);
    if (t == 2'd1) return (tq == 2'd1) && c && !d;
    if (t == 2'd2) return c;
    if (t == 2'd3) return !c;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_cur = '0; m_dly = '0; m_stat = '0; m_irq = 1'b0; m_typq = '0;
  endtask

  task automatic model_step();
    logic [N-1:0] ev, cm;
    for (int i = 0; i < N; i++)
      ev[i] = ref_evt(pin_type[2*i +: 2], m_typq[2*i +: 2], m_cur[i], m_dly[i]);
    cm = '0;
    if (bus_we && bus_addr == 2'd2) cm[LO-1:0] = bus_wdata;
    if (bus_we && bus_addr == 2'd3) cm[N-1:LO] = bus_wdata[HI-1:0];
    m_irq  = |(m_stat & pin_en);
    m_stat = (m_stat & ~cm) | ev;
    m_dly  = m_cur;
    m_cur  = m_s1;
    m_s1   = pin_in;
    m_typq = pin_type;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_we = 1'b0; bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic set_type(int p, logic [1:0] t);
    pin_type[2*p +: 2] = t;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; pin_in = '0; pin_type = '0; pin_en = '1;
    bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
    model_reset();
    #11;
    rst_n = 1'b1;
    tick();
    rd(2'd0, v); chk("R1 lower status", v, 32'h0);
    rd(2'd1, v); chk("R1 upper status", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2: rising edge timing and stickiness
    set_type(3, 2'd1); ticks(2);
    pin_in[3] = 1'b1;
    ticks(2);
    rd(2'd0, v); chk("R2 not yet after two edges", v, 32'h0);
    tick();
    rd(2'd0, v); chk("R2 set on third edge", v, 32'h8);
    chk("R10 irq lags status", {31'b0, irq}, 32'h0);
    tick();
    chk("R10 irq asserted", {31'b0, irq}, 32'h1);
    pin_in[3] = 1'b0; ticks(3);
    rd(2'd0, v); chk("R2 sticky after pin falls", v, 32'h8);

    // R3: masked clear
    set_type(4, 2'd1); tick();
    pin_in[4] = 1'b1; ticks(3);
    rd(2'd0, v); chk("R3 before clear", v, 32'h18);
    wr(2'd2, 32'h8);
    rd(2'd0, v); chk("R3 only masked bit cleared", v, 32'h10);

    // R4: edge on pin 6 while bit 4 is cleared
    set_type(6, 2'd1); tick();
    pin_in[6] = 1'b1; ticks(2);
    wr(2'd2, 32'h10);
    rd(2'd0, v); chk("R4 edge survives clear of other bit", v, 32'h40);

    // R5: edge on pin 6 while bit 6 itself is cleared
    pin_in[6] = 1'b0; ticks(3);
    pin_in[6] = 1'b1; ticks(2);
    wr(2'd2, 32'h40);
    rd(2'd0, v); chk("R5 edge survives clear of same bit", v, 32'h40);
    wr(2'd2, 32'h40);
    rd(2'd0, v); chk("R5 later clear takes effect", v, 32'h0);

    // R6: high level
    pin_in[8] = 1'b1; set_type(8, 2'd2); ticks(3);
    rd(2'd0, v); chk("R6 high level sets", v, 32'h100);
    wr(2'd2, 32'h100);
    rd(2'd0, v); chk("R6 clear while high re-asserts", v, 32'h100);
    pin_in[8] = 1'b0; ticks(3);
    wr(2'd2, 32'h100);
    rd(2'd0, v); chk("R6 clear after pin low", v, 32'h0);
    set_type(8, 2'd0);

    // R7: low level
    set_type(9, 2'd3); ticks(2);
    rd(2'd0, v); chk("R7 low level sets", v, 32'h200);
    pin_in[9] = 1'b1; ticks(3);
    wr(2'd2, 32'h200);
    rd(2'd0, v); chk("R7 clear after pin high", v, 32'h0);
    set_type(9, 2'd0);

    // R8: disabled pin toggles
    pin_in[10] = 1'b1; ticks(3);
    pin_in[10] = 1'b0; ticks(3);
    rd(2'd0, v); chk("R8 off pin never sets", v, 32'h0);

    // R9: mode switch to rising in the edge cycle
    pin_in[11] = 1'b1; ticks(2);
    set_type(11, 2'd1); ticks(3);
    rd(2'd0, v); chk("R9 no event on mode change", v, 32'h0);

    // R12: upper bank
    set_type(35, 2'd1); tick();
    pin_in[35] = 1'b1; ticks(3);
    rd(2'd1, v); chk("R12 upper bit set", v, 32'h8);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R12 lower clear spares upper", v, 32'h8);
    // R11: reads without side effects
    rd(2'd1, v); rd(2'd1, v2); chk("R11 repeated read stable", v2, v);
    rd(2'd2, v); chk("R11 clear address reads zero", v, 32'h0);
    pin_en = '0; ticks(2);
    chk("R10 masked status gives no irq", {31'b0, irq}, 32'h0);
    pin_en = '1;
    wr(2'd3, 32'h8);
    rd(2'd1, v); chk("R12 upper clear", v, 32'h0);

    // random phase against the reference model
    for (int c = 0; c < 4000; c++) begin
      pin_in[LO-1:0] ^= ($urandom & $urandom & $urandom);
      pin_in[N-1:LO] ^= 8'($urandom & $urandom & $urandom);
      if ($urandom % 4 == 0) set_type($urandom % N, 2'($urandom));
      if ($urandom % 16 == 0) pin_en = {8'($urandom), 32'($urandom)};
      if ($urandom % 4 == 0) begin
        bus_we = 1'b1; bus_addr = 2'd2 + 2'($urandom % 2); bus_wdata = $urandom;
      end
      tick();
      bus_we = 1'b0;
      rd(2'd0, v); chk("R2 R3 R4 R5 R6 R7 random lower", v, m_stat[LO-1:0]);
      rd(2'd1, v); chk("R12 random upper", v, {24'b0, m_stat[N-1:LO]});
      chk("R10 random irq", {31'b0, irq}, {31'b0, m_irq});
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule